// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Receiver

This block takes bits from one wire that rests low and gets no clock of its own. The sender codes each bit in how long it holds the wire high. A short high pulse is a 0 and a long one is a 1. Widths in a band between the two are rejected as ambiguous. Pulses too narrow to be real are dropped as glitches. The sender must also keep the wire low for a minimum time between pulses.

The raw wire is first brought into the clock domain by a two-flop synchronizer. Widths and gaps are then counted in clock cycles. When a pulse ends, its bit is decided, a one-cycle strobe is raised carrying the bit value, and the bit is shifted into a parameterizable shift register in arrival order. Malformed pulses and short gaps set sticky error flags that only a synchronous reset clears. Every threshold is a parameter in clock cycles: `MIN_W`, `ZERO_MAX`, `ONE_MIN`, `GAP_MIN` and `SREG_W`.

Top module: `pwrx_decoder`

## Requirements
- R1: A synchronous reset clears the shift register, both error flags and the strobe to 0.
- R2: A wire held steadily low produces no strobe and leaves all outputs unchanged.
- R3: A high pulse of MIN_W to ZERO_MAX cycles (inclusive) decodes as bit value 0. The strobe rises in the cycle after the third rising clock edge that follows the wire's fall.
- R4: A high pulse of ONE_MIN cycles or longer decodes as bit value 1, however long the pulse lasts.
- R5: A high pulse shorter than MIN_W cycles is ignored: no strobe, no flag, and the shift register is unchanged.
- R6: A high pulse longer than ZERO_MAX and shorter than ONE_MIN produces no strobe and sets width_err_o. The flag stays set until reset.
- R7: If a non-glitch pulse begins after fewer than GAP_MIN low cycles since the previous non-glitch pulse ended, gap_err_o is set and stays set until reset. That pulse is still decoded. A gap of exactly GAP_MIN cycles, or the first pulse after reset, raises no flag.
- R8: A glitch pulse neither restarts the gap timer nor raises gap_err_o. Low time on both sides of the glitch adds up toward GAP_MIN.
- R9: Each decoded bit enters shreg_o at bit 0 while older bits move one place toward the MSB. After SREG_W bits, the first bit sits in the MSB; for example, short, long, short, short, long, long gives 6'b010011.
- R10: bit_valid_o is high for exactly one cycle per decoded bit. shreg_o shows that bit in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wire_i | input | 1 | Raw serial wire, idles low |
| shreg_o | output | SREG_W | Shift register contents, newest bit at bit 0 |
| bit_valid_o | output | 1 | One-cycle strobe per decoded bit |
| bit_value_o | output | 1 | Value of the decoded bit, valid with the strobe |
| width_err_o | output | 1 | Sticky flag: an ambiguous pulse width was seen |
| gap_err_o | output | 1 | Sticky flag: a pulse began before the minimum low gap |

## Verification
A wrong width count shows up at the falling edge of the same pulse. Within three clock edges, the strobe, the bit value or width_err_o is wrong. A gap counter that restarts or saturates wrongly shows up in gap_err_o at the end of the next accepted pulse. A shift register that slips or loses a bit shows up in shreg_o one cycle after the strobe, and a scoreboard of expected bits shows a dropped or extra strobe at the pulse that caused it. Boundary widths on both sides of every threshold are driven so that an off-by-one in any comparison changes a port value.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;
    // Outcome of measuring one high pulse
    typedef enum logic [1:0] {
        PK_GLITCH = 2'd0,
        PK_ZERO   = 2'd1,
        PK_AMBIG  = 2'd2,
        PK_ONE    = 2'd3
    } pulse_kind_e;
endpackage

// File: rtl/pwrx_sync.sv
module pwrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic raw_i,
    output logic lvl_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], raw_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrx_classify.sv
module pwrx_classify
    import pwrx_pkg::*;
#(
    parameter int MIN_W    = 3,
    parameter int ZERO_MAX = 10,
    parameter int ONE_MIN  = 40,
    parameter int GAP_MIN  = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic bit_valid_o,
    output logic bit_value_o,
    output logic width_err_o,
    output logic gap_err_o
);
    localparam int CNT_W = $clog2(ONE_MIN + 1);
    localparam int GAP_W = $clog2(GAP_MIN + 1);
    localparam logic [CNT_W-1:0] MIN_L  = CNT_W'(MIN_W);
    localparam logic [CNT_W-1:0] ZMAX_L = CNT_W'(ZERO_MAX);
    localparam logic [CNT_W-1:0] ONE_L  = CNT_W'(ONE_MIN);
    localparam logic [GAP_W-1:0] GAP_L  = GAP_W'(GAP_MIN);

    typedef struct packed {
        logic             lvl;     // level seen last cycle
        logic [CNT_W-1:0] wcnt;    // high cycles of current pulse, saturating
        logic [GAP_W-1:0] gcnt;    // low cycles since last accepted pulse
        logic             gshort;  // gap was short at this pulse's rise
        logic             valid;
        logic             value;
        logic             werr;
        logic             gerr;
    } cls_state_t;

    cls_state_t st_d, st_q;
    pulse_kind_e kind_d;
    logic rise_d, fall_d;

    function automatic pulse_kind_e kind_of(input logic [CNT_W-1:0] w);
        if (w < MIN_L)       return PK_GLITCH;
        else if (w <= ZMAX_L) return PK_ZERO;
        else if (w >= ONE_L)  return PK_ONE;
        else                  return PK_AMBIG;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.lvl   = lvl_i;
        rise_d     = lvl_i && !st_q.lvl;
        fall_d     = !lvl_i && st_q.lvl;
        kind_d     = kind_of(st_q.wcnt);

        // width measurement
        if (rise_d) begin
            st_d.wcnt   = CNT_W'(1);
            st_d.gshort = (st_q.gcnt < GAP_L);
        end else if (lvl_i && st_q.wcnt < ONE_L) begin
            st_d.wcnt = st_q.wcnt + CNT_W'(1);
        end

        // decision on the falling edge; glitches leave gap timing alone
        if (fall_d && kind_d != PK_GLITCH) begin
            st_d.gcnt = GAP_W'(1);
            if (st_q.gshort) st_d.gerr = 1'b1;
            if (kind_d == PK_AMBIG) begin
                st_d.werr = 1'b1;
            end else begin
                st_d.valid = 1'b1;
                st_d.value = (kind_d == PK_ONE);
            end
        end else if (!lvl_i && st_q.gcnt < GAP_L) begin
            st_d.gcnt = st_q.gcnt + GAP_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q      <= '0;
            st_q.gcnt <= GAP_L;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_valid_o = st_q.valid;
    assign bit_value_o = st_q.value;
    assign width_err_o = st_q.werr;
    assign gap_err_o   = st_q.gerr;

    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (!st_q.valid && !st_q.werr && !st_q.gerr));
    p_strobe_after_fall_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.valid |-> ($past(st_q.lvl) && !st_q.lvl));
    p_werr_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.werr |=> st_q.werr);
    p_gerr_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.gerr |=> st_q.gerr);
    p_strobe_one_cycle_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.valid |=> !st_q.valid);
endmodule

// File: rtl/pwrx_shreg.sv
module pwrx_shreg #(
    parameter int WIDTH = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (shift_i) data_d = {data_q[WIDTH-2:0], bit_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) data_q <= '0;
        else       data_q <= data_d;
    end

    assign data_o = data_q;

    p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !shift_i |=> $stable(data_q));
    p_shift_in_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        shift_i |=> (data_q[0] == $past(bit_i)));
endmodule

// File: rtl/pwrx_decoder.sv
module pwrx_decoder #(
    parameter int SREG_W   = 6,
    parameter int MIN_W    = 3,
    parameter int ZERO_MAX = 10,
    parameter int ONE_MIN  = 40,
    parameter int GAP_MIN  = 12
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wire_i,
    output logic [SREG_W-1:0] shreg_o,
    output logic              bit_valid_o,
    output logic              bit_value_o,
    output logic              width_err_o,
    output logic              gap_err_o
);
    logic lvl_s;

    pwrx_sync #(.STAGES(2)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .raw_i (wire_i),
        .lvl_o (lvl_s)
    );

    pwrx_classify #(
        .MIN_W    (MIN_W),
        .ZERO_MAX (ZERO_MAX),
        .ONE_MIN  (ONE_MIN),
        .GAP_MIN  (GAP_MIN)
    ) cls_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .lvl_i       (lvl_s),
        .bit_valid_o (bit_valid_o),
        .bit_value_o (bit_value_o),
        .width_err_o (width_err_o),
        .gap_err_o   (gap_err_o)
    );

    pwrx_shreg #(.WIDTH(SREG_W)) sreg_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (bit_valid_o),
        .bit_i   (bit_value_o),
        .data_o  (shreg_o)
    );

    p_idle_no_bit_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!lvl_s && $past(!lvl_s)) |=> !bit_valid_o);
endmodule

// File: tb/pwrx_decoder_tb_top.sv
module pwrx_decoder_tb_top;
    localparam int SREG_W   = 6;
    localparam int MIN_W    = 3;
    localparam int ZERO_MAX = 10;
    localparam int ONE_MIN  = 40;
    localparam int GAP_MIN  = 12;
    localparam int LOW      = GAP_MIN + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wire_in = 1'b0;
    logic [SREG_W-1:0] shreg;
    logic bv, bval, werr, gerr;

    int n_tests = 0;
    int n_fail  = 0;
    int n_strobes = 0;
    bit exp_q[$];
    logic [SREG_W-1:0] model_sreg = '0;
    bit pend = 1'b0;
    bit prev_bv = 1'b0;

    always #2 clk = ~clk;

    pwrx_decoder #(
        .SREG_W(SREG_W), .MIN_W(MIN_W), .ZERO_MAX(ZERO_MAX),
        .ONE_MIN(ONE_MIN), .GAP_MIN(GAP_MIN)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .wire_i(wire_in), .shreg_o(shreg),
        .bit_valid_o(bv), .bit_value_o(bval),
        .width_err_o(werr), .gap_err_o(gerr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop and shift-register model
    always @(negedge clk) begin
        if (rst) begin
            pend = 1'b0;
            prev_bv = 1'b0;
        end else begin
            if (pend) begin
                chk(shreg == model_sreg, "R10", "shreg after strobe", int'(shreg), int'(model_sreg));
                pend = 1'b0;
            end
            if (bv) begin
                n_strobes++;
                chk(!prev_bv, "R10", "strobe longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R4", "unexpected strobe", int'(bval), -1);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(bval == e, "R3/R4", "decoded bit", int'(bval), int'(e));
                    model_sreg = {model_sreg[SREG_W-2:0], e};
                    pend = 1'b1;
                end
            end
            prev_bv = bv;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        wire_in = 1'b0;
        repeat (4) @(negedge clk);
        exp_q.delete();
        model_sreg = '0;
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // kind: 0 or 1 expects that bit, 2 expects no bit
    task automatic pulse(input int hi, input int lo, input int kind);
        if (kind < 2) exp_q.push_back(kind[0]);
        wire_in = 1'b1;
        repeat (hi) @(negedge clk);
        wire_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic drained(input string req);
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, req, "expected bits still pending", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int s0;
        logic [SREG_W-1:0] saved;
        do_reset();
        // R1 reset state
        chk(shreg == '0, "R1", "shreg after reset", int'(shreg), 0);
        chk(!werr && !gerr, "R1", "flags after reset", int'({werr, gerr}), 0);
        chk(!bv, "R1", "strobe after reset", int'(bv), 0);

        // R2 idle
        s0 = n_strobes;
        repeat (60) @(negedge clk);
        chk(n_strobes == s0, "R2", "strobes while idle", n_strobes - s0, 0);
        chk(shreg == '0, "R2", "shreg while idle", int'(shreg), 0);

        // R9 order: short long short short long long -> 010011
        pulse(5, LOW, 0);  pulse(50, LOW, 1); pulse(6, LOW, 0);
        pulse(4, LOW, 0);  pulse(45, LOW, 1); pulse(60, LOW, 1);
        drained("R9");
        chk(shreg == 6'b010011, "R9", "code 010011", int'(shreg), 6'b010011);
        chk(!werr && !gerr, "R7", "no flags on clean frame", int'({werr, gerr}), 0);

        // R3/R4 boundaries
        pulse(MIN_W, LOW, 0); pulse(ZERO_MAX, LOW, 0);
        pulse(ONE_MIN, LOW, 1); pulse(300, LOW, 1);
        drained("R4");
        chk(shreg[3:0] == 4'b0011, "R4", "boundary widths", int'(shreg[3:0]), 3);

        // R3 latency: strobe in the cycle after the third edge after the fall
        wire_in = 1'b1;
        exp_q.push_back(1'b0);
        repeat (5) @(negedge clk);
        wire_in = 1'b0;
        @(negedge clk); chk(!bv, "R3", "strobe 1 edge after fall", int'(bv), 0);
        @(negedge clk); chk(!bv, "R3", "strobe 2 edges after fall", int'(bv), 0);
        @(negedge clk); chk(bv, "R3", "strobe 3 edges after fall", int'(bv), 1);
        repeat (LOW) @(negedge clk);
        drained("R3");

        // R5 glitches ignored
        saved = shreg;
        s0 = n_strobes;
        pulse(MIN_W - 1, LOW, 2); pulse(1, LOW, 2);
        repeat (5) @(negedge clk);
        chk(n_strobes == s0, "R5", "strobes for glitches", n_strobes - s0, 0);
        chk(shreg == saved, "R5", "shreg unchanged by glitch", int'(shreg), int'(saved));
        chk(!werr && !gerr, "R5", "flags after glitch", int'({werr, gerr}), 0);

        // R8 glitch does not restart gap timer
        pulse(5, GAP_MIN - 2, 0);
        pulse(2, 3, 2);
        pulse(5, LOW, 0);
        drained("R8");
        chk(!gerr, "R8", "gap flag after glitch in gap", int'(gerr), 0);

        // R7 gap exactly at minimum
        pulse(5, GAP_MIN, 0);
        pulse(5, LOW, 0);
        drained("R7");
        chk(!gerr, "R7", "gap flag at exact minimum", int'(gerr), 0);

        // R7 gap one short: flag, bit still decoded
        pulse(5, GAP_MIN - 1, 0);
        pulse(50, LOW, 1);
        drained("R7");
        chk(gerr, "R7", "gap flag on short gap", int'(gerr), 1);
        chk(shreg[1:0] == 2'b01, "R7", "bits decoded despite short gap", int'(shreg[1:0]), 1);
        pulse(5, LOW, 0);
        drained("R7");
        chk(gerr, "R7", "gap flag sticky", int'(gerr), 1);

        // R6 ambiguous widths
        do_reset();
        s0 = n_strobes;
        pulse(ZERO_MAX + 1, LOW, 2);
        repeat (3) @(negedge clk);
        chk(werr, "R6", "width flag low side", int'(werr), 1);
        pulse(ONE_MIN - 1, LOW, 2);
        chk(n_strobes == s0, "R6", "no strobe for ambiguous", n_strobes - s0, 0);
        pulse(5, LOW, 0);
        drained("R6");
        chk(werr, "R6", "width flag sticky", int'(werr), 1);
        chk(!gerr, "R6", "no gap flag", int'(gerr), 0);
        chk(shreg == 6'b000000, "R6", "only a zero shifted", int'(shreg), 0);

        // R1 reset clears flags and data
        pulse(50, LOW, 1);
        drained("R1");
        do_reset();
        chk(!werr && !gerr, "R1", "flags cleared by reset", int'({werr, gerr}), 0);
        chk(shreg == '0, "R1", "shreg cleared by reset", int'(shreg), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule